// File: doc/BRIEF.md
# Serial Converter Command Port

This block is the digital serial front end of a multiplexed sampling converter. A host selects it with an active-low chip select and clocks it with a serial clock. On each rising serial-clock edge the block takes one command bit from the data input. On each falling edge it moves the previous conversion result one bit further out on the data output. The first result bit is already on the output before any clock edge arrives. It appears when chip select falls or, when chip select stays low, when the sequencer reports the end of a conversion.

Once a transfer is complete, the block decodes the first bits received into an operation and a channel and hands them to a conversion sequencer. It takes back a result word and a busy level from the sequencer. The transfer length is 13 or 9 bits and follows the last programmed conversion mode. A data-output-ready flag brackets each transfer. A read-only input lets the host fetch the stored result again without starting anything. All serial inputs are treated as synchronous to the fabric clock and are edge-detected against a registered copy.

Top module: `sadc_serial_if`

## Requirements
- R1: After reset `dor` is 1, `do_oe` is 0, `cmd_valid` is 0 and the transfer length is 13 bits.
- R2: While a transfer is armed and `conv_rd` was 0 at its start, `di` is sampled on each `sclk` rising edge. The first 6 bits received, first bit most significant, form the command: bits [5:3] are the mode and bits [2:0] are the channel reported on `cmd_chan`.
- R3: The sign bit of the output word (`res_word[12]`) is on `do_o` one cycle after `cs_n` falls. Each `sclk` falling edge then presents the next bit, magnitude most significant first.
- R4: `do_oe` is 0 in the cycle after any cycle in which `cs_n` is 1. It is 1 during an accepted transfer.
- R5: Mode 0 sets a 13-bit length (sign then `res_word[11:0]`). Mode 1 sets a 9-bit length (sign then `res_word[11:4]`). Other modes keep the length. A new length applies from the next transfer on.
- R6: `dor` is 0 from the start of a transfer until the falling `sclk` edge that completes the programmed count, then 1.
- R7: `cmd_valid` pulses for one cycle, together with `dor` rising, only when a full transfer completes. A transfer ended early by `cs_n` rising commits nothing and leaves the length unchanged.
- R8: With `cs_n` held low after a completed transfer, a `conv_done` pulse re-arms the port: `dor` goes 0 and the new sign bit appears on `do_o` one cycle later.
- R9: If `conv_rd` is 1 when a transfer starts, the stored result is shifted out unchanged, `di` is ignored, no `cmd_valid` is issued and the length is kept.
- R10: A read-only start while `busy` is 1 is refused: `do_oe` stays 0, `dor` stays 1 and `sclk` has no effect until `cs_n` rises.
- R11: `cmd_op` encodes mode 0 or 1 as 0 (convert), mode 2 as 1 (calibrate), mode 3 as 2 (zero offset) and modes 4 to 7 as 3 (no operation). `cmd_short` gives the length in force after the commit (1 means 9 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select |
| di | input | 1 | Serial command bit |
| conv_rd | input | 1 | 1 selects a read-only transfer |
| busy | input | 1 | Sequencer is converting, calibrating or zeroing |
| conv_done | input | 1 | One-cycle pulse: new result on `res_word` |
| res_word | input | 13 | Sign (bit 12) and magnitude result |
| do_o | output | 1 | Serial result bit |
| do_oe | output | 1 | Output enable for the tri-state pad |
| dor | output | 1 | High when no result bits are pending |
| cmd_valid | output | 1 | One-cycle command commit pulse |
| cmd_op | output | 2 | Decoded operation |
| cmd_chan | output | 3 | Channel address |
| cmd_short | output | 1 | 1 when the word length is 9 bits |

## Verification
The bench aims at the places where the bit count and the first-bit timing can slip. If the counter were not reloaded at each select, a transfer cut short would shift every later word. If the sign bit were launched on a clock edge and not on select, every word would come out rotated. If the length changed before the transfer that programmed it had finished, that transfer would end early. The read-only paths are also covered: a design that latched `di` there would change the length or issue a spurious command, and one that ignored `busy` would enable the output during a conversion. Finally, with select held low, a missing re-arm on `conv_done` leaves `dor` high and the port out of step.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int SADC_MODE_W = 3;

  typedef enum logic [1:0] {
    OP_CONV = 2'd0,
    OP_CAL  = 2'd1,
    OP_ZERO = 2'd2,
    OP_NONE = 2'd3
  } sadc_op_e;

  typedef struct packed {
    sadc_op_e op;
    logic     set_len;
    logic     long_len;
  } sadc_dec_t;

  // Mode field decode; convert modes also choose the output word length.
  function automatic sadc_dec_t sadc_decode(input logic [SADC_MODE_W-1:0] m);
    sadc_dec_t d;
    d.op       = OP_NONE;
    d.set_len  = 1'b0;
    d.long_len = 1'b1;
    case (m)
      3'd0: begin d.op = OP_CONV; d.set_len = 1'b1; d.long_len = 1'b1; end
      3'd1: begin d.op = OP_CONV; d.set_len = 1'b1; d.long_len = 1'b0; end
      3'd2: d.op = OP_CAL;
      3'd3: d.op = OP_ZERO;
      default: d.op = OP_NONE;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/sadc_edge.sv
module sadc_edge #(
  parameter int         LANES = 2,
  parameter logic [1:0] IDLE  = 2'b10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] lvl,
  output logic [LANES-1:0] prev
);
  // One registered copy per lane; each lane resets to its own idle level.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) prev[g] <= IDLE[g];
      else     prev[g] <= lvl[g];
    end
  end
endmodule

// File: rtl/sadc_cmd_capture.sv
module sadc_cmd_capture
  import sadc_pkg::*;
#(
  parameter int CHAN_W = 3,
  localparam int CMD_W  = SADC_MODE_W + CHAN_W,
  localparam int RCNT_W = $clog2(CMD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              armed,
  input  logic              ro,
  input  logic              sclk_rise,
  input  logic              di,
  input  logic              xfer_done,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [CHAN_W-1:0] cmd_chan,
  output logic              cmd_short,
  output logic              cur_long
);
  logic [CMD_W-1:0]  sr;
  logic [RCNT_W-1:0] rcnt;
  sadc_dec_t         dec;

  assign dec = sadc_decode(sr[CMD_W-1 -: SADC_MODE_W]);

  always_ff @(posedge clk) begin
    if (rst) begin
      sr        <= '0;
      rcnt      <= '0;
      cmd_valid <= 1'b0;
      cmd_op    <= OP_NONE;
      cmd_chan  <= '0;
      cmd_short <= 1'b0;
      cur_long  <= 1'b1;
    end else begin
      cmd_valid <= 1'b0;
      if (start) begin
        rcnt <= '0;
      end else if (armed && !ro && sclk_rise && (rcnt < RCNT_W'(CMD_W))) begin
        sr   <= {sr[CMD_W-2:0], di};
        rcnt <= rcnt + RCNT_W'(1);
      end
      if (xfer_done && !ro) begin
        cmd_valid <= 1'b1;
        cmd_op    <= dec.op;
        cmd_chan  <= sr[CHAN_W-1:0];
        cmd_short <= dec.set_len ? !dec.long_len : !cur_long;
        if (dec.set_len) cur_long <= dec.long_len;
      end
    end
  end

  AST_RO_HOLDS_CMD: assert property (@(posedge clk) disable iff (rst)
    (armed && ro && sclk_rise) |=> $stable(sr)); // R9
  AST_LEN_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |-> $stable(cur_long) || $past(rst)); // R7
endmodule

// File: rtl/sadc_out_shift.sv
module sadc_out_shift #(
  parameter int MAG_W     = 12,
  parameter int SHORT_MAG = 8,
  localparam int LONG_LEN  = MAG_W + 1,
  localparam int SHORT_LEN = SHORT_MAG + 1,
  localparam int CNT_W     = $clog2(LONG_LEN + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_n,
  input  logic         cs_fall,
  input  logic         sclk_fall,
  input  logic         conv_rd,
  input  logic         busy,
  input  logic         conv_done,
  input  logic [MAG_W:0] res_word,
  input  logic         cur_long,
  output logic         do_o,
  output logic         do_oe,
  output logic         dor,
  output logic         armed,
  output logic         ro,
  output logic         start,
  output logic         xfer_done
);
  logic [LONG_LEN-1:0] sh;
  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    len_now;
  logic [MAG_W:0]      store;
  logic [MAG_W:0]      src_word;
  logic                blocked;
  logic                refuse;
  logic                cont_arm;

  // Left-aligned word: sign first, then magnitude truncated to the length.
  function automatic logic [LONG_LEN-1:0] fmt(input logic [MAG_W:0] w, input logic lng);
    if (lng) return w;
    return {w[MAG_W], w[MAG_W-1 -: SHORT_MAG], {(LONG_LEN-SHORT_LEN){1'b0}}};
  endfunction

  assign len_now   = cur_long ? CNT_W'(LONG_LEN) : CNT_W'(SHORT_LEN);
  assign refuse    = cs_fall && conv_rd && busy;
  assign cont_arm  = !cs_n && !cs_fall && !armed && !blocked && conv_done;
  assign start     = (cs_fall && !refuse) || cont_arm;
  assign src_word  = conv_done ? res_word : store;
  assign xfer_done = armed && !cs_n && sclk_fall && (cnt == CNT_W'(1));
  assign do_o      = sh[LONG_LEN-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      cnt     <= '0;
      store   <= '0;
      armed   <= 1'b0;
      dor     <= 1'b1;
      do_oe   <= 1'b0;
      ro      <= 1'b0;
      blocked <= 1'b0;
    end else begin
      if (conv_done) store <= res_word;
      if (cs_n) begin
        armed   <= 1'b0;
        dor     <= 1'b1;
        do_oe   <= 1'b0;
        blocked <= 1'b0;
      end else if (start) begin
        armed <= 1'b1;
        dor   <= 1'b0;
        do_oe <= 1'b1;
        ro    <= conv_rd;
        sh    <= fmt(src_word, cur_long);
        cnt   <= len_now;
      end else if (refuse) begin
        blocked <= 1'b1;
        do_oe   <= 1'b0;
      end else if (armed && sclk_fall) begin
        sh  <= {sh[LONG_LEN-2:0], 1'b0};
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) begin
          armed <= 1'b0;
          dor   <= 1'b1;
        end
      end
    end
  end

  AST_OE_OFF_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !do_oe); // R4
  AST_REFUSED_QUIET: assert property (@(posedge clk) disable iff (rst)
    refuse |=> (!do_oe && dor)); // R10
  AST_SIGN_ON_SELECT: assert property (@(posedge clk) disable iff (rst)
    (cs_fall && !refuse) |=> (!dor && do_oe && (do_o == $past(src_word[MAG_W])))); // R3
  AST_CONT_REARM: assert property (@(posedge clk) disable iff (rst)
    cont_arm |=> (!dor && (do_o == $past(res_word[MAG_W])))); // R8
  AST_LEN_LOADED: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> ((cnt == CNT_W'(LONG_LEN)) || (cnt == CNT_W'(SHORT_LEN)))); // R5
endmodule

// File: rtl/sadc_serial_if.sv
module sadc_serial_if
  import sadc_pkg::*;
#(
  parameter int MAG_W     = 12,
  parameter int SHORT_MAG = 8,
  parameter int CHAN_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              di,
  input  logic              conv_rd,
  input  logic              busy,
  input  logic              conv_done,
  input  logic [MAG_W:0]    res_word,
  output logic              do_o,
  output logic              do_oe,
  output logic              dor,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [CHAN_W-1:0] cmd_chan,
  output logic              cmd_short
);
  logic [1:0] lvl_q;
  logic       sclk_rise, sclk_fall, cs_fall;
  logic       armed, ro, start, xfer_done, cur_long;

  sadc_edge #(.LANES(2), .IDLE(2'b10)) u_edge (
    .clk (clk),
    .rst (rst),
    .lvl ({cs_n, sclk}),
    .prev(lvl_q)
  );

  assign sclk_rise = sclk && !lvl_q[0];
  assign sclk_fall = !sclk && lvl_q[0];
  assign cs_fall   = !cs_n && lvl_q[1];

  sadc_out_shift #(.MAG_W(MAG_W), .SHORT_MAG(SHORT_MAG)) u_out (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .cs_fall  (cs_fall),
    .sclk_fall(sclk_fall),
    .conv_rd  (conv_rd),
    .busy     (busy),
    .conv_done(conv_done),
    .res_word (res_word),
    .cur_long (cur_long),
    .do_o     (do_o),
    .do_oe    (do_oe),
    .dor      (dor),
    .armed    (armed),
    .ro       (ro),
    .start    (start),
    .xfer_done(xfer_done)
  );

  sadc_cmd_capture #(.CHAN_W(CHAN_W)) u_cmd (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .armed    (armed),
    .ro       (ro),
    .sclk_rise(sclk_rise),
    .di       (di),
    .xfer_done(xfer_done),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_chan (cmd_chan),
    .cmd_short(cmd_short),
    .cur_long (cur_long)
  );

  AST_COMMIT_AT_LAST_BIT: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (dor && !$past(dor))); // R7
  AST_RO_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !$past(ro)); // R9
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid); // R7
endmodule

// File: tb/sadc_serial_if_tb.sv
`timescale 1ns/1ps
module sadc_serial_if_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0, cs_n = 1'b1, di = 1'b0, conv_rd = 1'b0;
  logic        busy = 1'b0, conv_done = 1'b0;
  logic [12:0] res_word = '0;
  logic        do_o, do_oe, dor, cmd_valid, cmd_short;
  logic [1:0]  cmd_op;
  logic [2:0]  cmd_chan;

  int   nchk = 0, nfail = 0;
  bit   finished = 0;
  logic long_m = 1'b1;
  logic [12:0] store_m = '0;

  always #2 clk = ~clk;

  sadc_serial_if dut_i (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .di(di), .conv_rd(conv_rd),
    .busy(busy), .conv_done(conv_done), .res_word(res_word), .do_o(do_o),
    .do_oe(do_oe), .dor(dor), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_chan(cmd_chan), .cmd_short(cmd_short)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] fmt_m(input logic [12:0] w, input logic lng);
    return lng ? w : {w[12], w[11:4], 4'b0};
  endfunction

  function automatic logic [1:0] op_m(input logic [2:0] m);
    if (m <= 3'd1) return 2'd0;
    if (m == 3'd2) return 2'd1;
    if (m == 3'd3) return 2'd2;
    return 2'd3;
  endfunction

  // Shift one whole word; first bit must already be presented.
  task automatic shift_word(input logic [5:0] cmd, input logic ro, input logic [12:0] w);
    logic [12:0] f;
    int len;
    f = fmt_m(w, long_m);
    len = long_m ? 13 : 9;
    check(do_o == f[12], "R3 sign bit first", do_o, f[12]);
    check(dor == 1'b0, "R6 dor low at start", dor, 0);
    for (int i = 0; i < len; i++) begin
      di = (i < 6) ? cmd[5-i] : 1'($urandom);
      sclk = 1'b1; @(negedge clk); @(negedge clk);
      sclk = 1'b0; @(negedge clk);
      if (i < len - 1) begin
        check(do_o == f[11-i], "R3 next bit", do_o, f[11-i]);
        check(dor == 1'b0, "R6 dor low mid word", dor, 0);
        check(cmd_valid == 1'b0, "R7 no early commit", cmd_valid, 0);
      end else begin
        check(dor == 1'b1, "R6 dor high after last", dor, 1);
        check(cmd_valid == !ro, "R7 R9 commit", cmd_valid, !ro);
        if (!ro) begin
          if (cmd[5:4] == 2'b00) long_m = !cmd[3];
          check(cmd_op == op_m(cmd[5:3]), "R11 op decode", cmd_op, op_m(cmd[5:3]));
          check(cmd_chan == cmd[2:0], "R2 channel", cmd_chan, cmd[2:0]);
          check(cmd_short == !long_m, "R5 R11 length flag", cmd_short, !long_m);
        end
      end
    end
  endtask

  task automatic xfer(input logic [5:0] cmd, input logic ro);
    conv_rd = ro; cs_n = 1'b0; @(negedge clk);
    check(do_oe == 1'b1, "R4 enabled when selected", do_oe, 1);
    shift_word(cmd, ro, store_m);
    cs_n = 1'b1; conv_rd = 1'b0; @(negedge clk);
    check(do_oe == 1'b0, "R4 disabled when deselected", do_oe, 0);
  endtask

  task automatic seq_run(input logic [5:0] cmd);
    busy = 1'b1;
    repeat (3) @(negedge clk);
    if (op_m(cmd[5:3]) == 2'd0) begin
      res_word = 13'($urandom); conv_done = 1'b1; store_m = res_word;
    end
    busy = 1'b0; @(negedge clk);
    conv_done = 1'b0; @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (5) @(negedge clk);
    rst = 1'b0; @(negedge clk);
    check(dor == 1'b1, "R1 dor reset", dor, 1);
    check(do_oe == 1'b0, "R1 oe reset", do_oe, 0);
    check(cmd_valid == 1'b0, "R1 cmd_valid reset", cmd_valid, 0);

    // Directed: long convert on channel 5 (length 13 from reset), then short.
    xfer(6'b000_101, 1'b0); seq_run(6'b000_101);
    xfer(6'b001_010, 1'b0); seq_run(6'b001_010);
    xfer(6'b010_111, 1'b0); seq_run(6'b010_111);   // short word, calibrate
    xfer(6'b000_001, 1'b0); seq_run(6'b000_001);

    // Random mix of modes, channels and read-only transfers.
    for (int k = 0; k < 30; k++) begin
      logic [5:0] c;
      c = 6'($urandom);
      if (($urandom % 4) == 0) begin
        xfer(c, 1'b1);   // R9 read-only replay
      end else begin
        xfer(c, 1'b0); seq_run(c);
      end
    end

    // R7: abort after 4 clocks of a short-length command.
    cs_n = 1'b0; @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      di = (i == 2); sclk = 1'b1; @(negedge clk); @(negedge clk);
      sclk = 1'b0; @(negedge clk);
      check(cmd_valid == 1'b0, "R7 no commit while aborted", cmd_valid, 0);
    end
    cs_n = 1'b1; @(negedge clk);
    check(cmd_valid == 1'b0, "R7 no commit after abort", cmd_valid, 0);
    check(dor == 1'b1, "R7 dor high after abort", dor, 1);
    xfer(6'b111_000, 1'b0);   // old length still in force

    // R10: refused read-only while busy.
    busy = 1'b1; conv_rd = 1'b1; cs_n = 1'b0; @(negedge clk);
    check(do_oe == 1'b0, "R10 oe stays off", do_oe, 0);
    check(dor == 1'b1, "R10 dor stays high", dor, 1);
    for (int i = 0; i < 3; i++) begin
      sclk = 1'b1; @(negedge clk); sclk = 1'b0; @(negedge clk);
      check(dor == 1'b1 && do_oe == 1'b0, "R10 sclk ignored", {dor, do_oe}, 2);
    end
    cs_n = 1'b1; conv_rd = 1'b0; busy = 1'b0; @(negedge clk);
    xfer(6'b110_011, 1'b1);   // R9 stored word intact

    // R8: select held low, end of conversion re-arms the port.
    xfer(6'b001_100, 1'b0);
    cs_n = 1'b0; @(negedge clk);
    shift_word(6'b000_110, 1'b0, store_m);
    busy = 1'b1; repeat (3) @(negedge clk);
    res_word = 13'h1ABC; conv_done = 1'b1; busy = 1'b0; store_m = res_word;
    @(negedge clk); conv_done = 1'b0;
    check(dor == 1'b0, "R8 dor low on re-arm", dor, 0);
    check(do_o == store_m[12], "R8 sign on end of conversion", do_o, store_m[12]);
    shift_word(6'b011_010, 1'b0, store_m);
    cs_n = 1'b1; @(negedge clk);
    check(do_oe == 1'b0, "R4 off at end", do_oe, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule